// File: doc/BRIEF.md
# Holdover-Capable Phase-Accumulator Oscillator

This block is the oscillator stage of a digital phase-locked loop. A phase register advances every clock cycle by a frequency word, and the top bit of that register is driven out as the synthesized clock. A two-bit mode input selects where the frequency word comes from:

- **Tracking:** the word is a fixed nominal value plus a signed correction from the loop filter. The correction is limited to a symmetric range first.
- **Holdover:** the word is the nominal value plus a correction recalled from frequency history.
- **Free-running:** the word is the nominal value alone.

While tracking, the block takes a sample of the limited correction once per sample period and keeps the two most recent samples. On entry to holdover it recalls the older of the two samples. The older sample is between one and two sample periods old, so a disturbance just before the reference was lost does not reach the holdover frequency. If fewer than two samples exist when holdover starts, the correction used is zero.

Top module: `nco_holdover`

## Requirements
- R1: A synchronous active-high reset sets `phase` to 0, `clk_out` to 0 and `freq_word` to NOMINAL_WORD, and discards all frequency history.
- R2: With `mode` = 2'b00 (tracking), `freq_word` one cycle later equals NOMINAL_WORD plus the sign-extended limited value of `corr_in`.
- R3: The correction is limited to the range from -MAX_CORR to +MAX_CORR before use, so `freq_word` never leaves NOMINAL_WORD ± MAX_CORR.
- R4: With `mode` = 2'b10 (free-running), `freq_word` one cycle later equals NOMINAL_WORD whatever `corr_in` is.
- R5: On each cycle out of reset, `phase` increases by the previous `freq_word`, modulo 2^FW. `clk_out` equals bit FW-1 of `phase`.
- R6: While tracking, a sample-period counter runs, and on every SAMPLE_CYCLES-th tracking cycle the limited correction is stored as the newest sample. At that moment the previous newest sample becomes the older sample. Holdover uses the older sample.
- R7: On entry to `mode` = 2'b01 (holdover), the recalled correction is latched. For as long as holdover lasts, `freq_word` stays at NOMINAL_WORD plus that value, unaffected by `corr_in`.
- R8: If holdover is entered before two samples exist since reset, `freq_word` becomes NOMINAL_WORD.
- R9: `mode` = 2'b11 behaves as free-running. The sample counter and the history advance only in tracking mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 tracking, 01 holdover, 10 or 11 free-running |
| corr_in | input | CW | Signed correction from the loop filter |
| freq_word | output | FW | Registered frequency word in use |
| phase | output | FW | Phase accumulator value |
| clk_out | output | 1 | Synthesized clock (accumulator MSB) |

## Verification
The following directed cases are run:

- **Constant corrections per sample period, then holdover.** Each period carries a different value, so the recalled frequency shows whether the older sample, the newer sample, or the live input was chosen.
- **Out-of-range corrections in both directions, including the most negative code.** These separate correct limiting from wrap-around or one-sided limiting.
- **Holdover entered after a single sample.** This case exposes a missing fallback to zero.

Random mode segments with random corrections and occasional resets then cover further cases:

- holdover re-entry after free-running
- history freezing outside tracking mode
- accumulator wrap

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    MODE_TRACK    = 2'b00,
    MODE_HOLD     = 2'b01,
    MODE_FREE     = 2'b10,
    MODE_FREE_ALT = 2'b11
  } nco_mode_e;
endpackage

// File: rtl/nco_clamp.sv
module nco_clamp #(
  parameter int CW       = 16,
  parameter int MAX_CORR = 4096
) (
  input  logic signed [CW-1:0] corr_raw,
  output logic signed [CW-1:0] corr_lim
);
  localparam logic signed [CW-1:0] POS_LIM = CW'(MAX_CORR);
  localparam logic signed [CW-1:0] NEG_LIM = -POS_LIM;

  always_comb begin
    if (corr_raw > POS_LIM)      corr_lim = POS_LIM;
    else if (corr_raw < NEG_LIM) corr_lim = NEG_LIM;
    else                         corr_lim = corr_raw;
  end
endmodule

// File: rtl/nco_history.sv
module nco_history #(
  parameter int CW            = 16,
  parameter int SAMPLE_CYCLES = 520000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic signed [CW-1:0] sample_in,
  output logic signed [CW-1:0] older,
  output logic                 ready
);
  localparam int CNT_W = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_CYCLES - 1);

  logic [CNT_W-1:0]     cnt;
  logic [1:0]           fill;
  logic signed [CW-1:0] newer;
  logic                 take;

  assign take  = run && (cnt == LAST);
  assign ready = fill[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fill  <= '0;
      newer <= '0;
      older <= '0;
    end else if (run) begin
      if (take) begin
        cnt   <= '0;
        older <= newer;
        newer <= sample_in;
        if (!fill[1]) fill <= fill + 2'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] step,
  output logic [FW-1:0] acc,
  output logic          msb
);
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end

  assign msb = acc[FW-1];
endmodule

// File: rtl/nco_holdover.sv
module nco_holdover #(
  parameter int            FW            = 32,
  parameter int            CW            = 16,
  parameter int            MAX_CORR      = 4096,
  parameter int            SAMPLE_CYCLES = 520000,
  parameter logic [FW-1:0] NOMINAL_WORD  = FW'(1) << (FW - 3)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic signed [CW-1:0] corr_in,
  output logic [FW-1:0]        freq_word,
  output logic [FW-1:0]        phase,
  output logic                 clk_out
);
  import nco_pkg::*;

  nco_mode_e            md;
  logic                 track_en, hold_en, entering, prev_hold, hist_ready;
  logic signed [CW-1:0] corr_lim, hist_older, hold_corr, hold_pick, sel_corr;

  assign md       = nco_mode_e'(mode);
  assign track_en = (md == MODE_TRACK);
  assign hold_en  = (md == MODE_HOLD);
  assign entering = hold_en && !prev_hold;

  nco_clamp #(.CW(CW), .MAX_CORR(MAX_CORR)) u_clamp (
    .corr_raw (corr_in),
    .corr_lim (corr_lim)
  );

  nco_history #(.CW(CW), .SAMPLE_CYCLES(SAMPLE_CYCLES)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .run       (track_en),
    .sample_in (corr_lim),
    .older     (hist_older),
    .ready     (hist_ready)
  );

  assign hold_pick = entering ? (hist_ready ? hist_older : '0) : hold_corr;

  always_comb begin
    case (md)
      MODE_TRACK: sel_corr = corr_lim;
      MODE_HOLD:  sel_corr = hold_pick;
      default:    sel_corr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_word <= NOMINAL_WORD;
      hold_corr <= '0;
      prev_hold <= 1'b0;
    end else begin
      freq_word <= NOMINAL_WORD + {{(FW-CW){sel_corr[CW-1]}}, sel_corr};
      prev_hold <= hold_en;
      if (entering) hold_corr <= hold_pick;
    end
  end

  nco_phase_acc #(.FW(FW)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .step (freq_word),
    .acc  (phase),
    .msb  (clk_out)
  );
endmodule

// File: rtl/nco_holdover_chk.sv
module nco_holdover_chk #(
  parameter int            FW           = 32,
  parameter int            MAX_CORR     = 4096,
  parameter logic [FW-1:0] NOMINAL_WORD = FW'(1) << (FW - 3)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [FW-1:0] freq_word,
  input logic [FW-1:0] phase,
  input logic          clk_out
);
  localparam logic [FW-1:0] LO = NOMINAL_WORD - FW'(MAX_CORR);
  localparam logic [FW-1:0] HI = NOMINAL_WORD + FW'(MAX_CORR);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (phase == '0) && (freq_word == NOMINAL_WORD) && !clk_out);

  a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase == FW'($past(phase) + $past(freq_word)));

  a_r3_word_range: assert property (@(posedge clk) disable iff (rst)
    (freq_word >= LO) && (freq_word <= HI));

  a_r4_free_nominal: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> freq_word == NOMINAL_WORD);

  a_r7_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) ##1 (mode == 2'b01) |=> $stable(freq_word));
endmodule

bind nco_holdover nco_holdover_chk #(
  .FW(FW), .MAX_CORR(MAX_CORR), .NOMINAL_WORD(NOMINAL_WORD)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode),
  .freq_word(freq_word), .phase(phase), .clk_out(clk_out)
);

// File: tb/test_nco_holdover.sv
module test_nco_holdover;
  localparam int          FW  = 32;
  localparam int          CW  = 16;
  localparam int          MAX = 4096;
  localparam int          SP  = 8;
  localparam logic [31:0] NOM = 32'h2000_0000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [1:0]           mode = 2'b00;
  logic signed [CW-1:0] corr_in = '0;
  logic [FW-1:0]        freq_word, phase;
  logic                 clk_out;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] m_fw = NOM, m_acc = '0;
  int m_cnt = 0, m_newer = 0, m_older = 0, m_fill = 0, m_hold = 0;
  bit m_prev_hold = 0;

  always #5 clk = ~clk;

  nco_holdover #(
    .FW(FW), .CW(CW), .MAX_CORR(MAX), .SAMPLE_CYCLES(SP), .NOMINAL_WORD(NOM)
  ) i_nco_holdover (
    .clk(clk), .rst(rst), .mode(mode), .corr_in(corr_in),
    .freq_word(freq_word), .phase(phase), .clk_out(clk_out)
  );

  function automatic int lim(input int c);
    if (c > MAX)  return MAX;
    if (c < -MAX) return -MAX;
    return c;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_step(input logic [1:0] md, input int c);
    int cc, sel;
    if (rst) begin
      m_fw = NOM; m_acc = '0; m_cnt = 0; m_newer = 0; m_older = 0;
      m_fill = 0; m_hold = 0; m_prev_hold = 0;
      return;
    end
    m_acc = m_acc + m_fw;
    cc = lim(c);
    if (md == 2'b00) sel = cc;
    else if (md == 2'b01) begin
      if (!m_prev_hold) m_hold = (m_fill >= 2) ? m_older : 0;
      sel = m_hold;
    end else sel = 0;
    m_fw = NOM + 32'(sel);
    if (md == 2'b00) begin
      if (m_cnt == SP - 1) begin
        m_older = m_newer; m_newer = cc; m_cnt = 0;
        if (m_fill < 2) m_fill++;
      end else m_cnt++;
    end
    m_prev_hold = (md == 2'b01);
  endtask

  task automatic tick(input logic [1:0] md, input int c);
    string tag;
    mode = md;
    corr_in = CW'(c);
    @(posedge clk);
    model_step(md, c);
    @(negedge clk);
    if (rst) tag = "R1";
    else case (md)
      2'b00: tag = "R2";
      2'b01: tag = "R7";
      2'b10: tag = "R4";
      default: tag = "R9";
    endcase
    check(tag, 64'(freq_word), 64'(m_fw));
    check("R5", 64'(phase), 64'(m_acc));
    check("R5", 64'(clk_out), 64'(m_acc[31]));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2'b00, 0);
    tick(2'b00, 0);
    check("R1", 64'(freq_word), 64'(NOM));
    check("R1", 64'(phase), 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R3: limiting in both directions
    tick(2'b00, MAX + 500);
    check("R3", 64'(freq_word), 64'(NOM + 32'(MAX)));
    tick(2'b00, -(MAX + 500));
    check("R3", 64'(freq_word), 64'(NOM - 32'(MAX)));
    tick(2'b00, -32768);
    check("R3", 64'(freq_word), 64'(NOM - 32'(MAX)));
    tick(2'b00, 32767);
    check("R3", 64'(freq_word), 64'(NOM + 32'(MAX)));

    // R4 / R9: free-running ignores corr_in
    tick(2'b10, 1234);
    check("R4", 64'(freq_word), 64'(NOM));
    tick(2'b11, -999);
    check("R9", 64'(freq_word), 64'(NOM));

    // R6: older sample is recalled
    do_reset();
    for (int i = 0; i < SP; i++) tick(2'b00, 100);
    for (int i = 0; i < SP; i++) tick(2'b00, 200);
    for (int i = 0; i < 3; i++) tick(2'b00, 300);
    tick(2'b01, 777);
    check("R6", 64'(freq_word), 64'(NOM + 32'd100));
    for (int i = 0; i < 5; i++) tick(2'b01, -50 * i);
    check("R7", 64'(freq_word), 64'(NOM + 32'd100));

    // R9: history frozen outside tracking
    for (int i = 0; i < 3 * SP; i++) tick(2'b10, 900);
    tick(2'b01, 0);
    check("R9", 64'(freq_word), 64'(NOM + 32'd100));

    // R8: holdover before two samples
    do_reset();
    for (int i = 0; i < SP; i++) tick(2'b00, 50);
    tick(2'b01, 3000);
    check("R8", 64'(freq_word), 64'(NOM));

    // Random segments
    do_reset();
    for (int s = 0; s < 200; s++) begin
      int r;
      int len;
      logic [1:0] md;
      r = $urandom_range(0, 99);
      md = (r < 55) ? 2'b00 : (r < 80) ? 2'b01 : (r < 93) ? 2'b10 : 2'b11;
      len = $urandom_range(1, 30);
      if ($urandom_range(0, 99) < 3) do_reset();
      for (int k = 0; k < len; k++) begin
        logic signed [15:0] rv;
        int c;
        rv = 16'($urandom);
        c = rv;
        if ($urandom_range(0, 1) == 0) c = $urandom_range(0, 12000) - 6000;
        tick(md, c);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule